// File: doc/BRIEF.md
# Address-Pointer Hazard and Sequence Checker

This block sits beside an instruction issue stage and inspects one decoded descriptor per issue slot. A descriptor states whether the slot holds an issued instruction. It also gives the register it writes (kind and 3-bit index), whether it forms an address, and if so from which pointer index and in which addressing mode. A 4-bit operation class and a fast-interrupt-context flag complete it. The checker flags three kinds of fault. The first is an instruction that reads a pointer, offset or modifier register one slot after that register was written. The second is a stack-pointer update followed at once by a bit-test jump on the stack-high or stack-low register. The third is an instruction that is forbidden while a fast interrupt routine runs.

The only state is a record of what the previous issued instruction wrote, held as one bit per register of each kind, plus a bit saying whether it updated the stack pointer. Slots with the valid bit low leave that record untouched, so the two-instruction distance counts only issued instructions. The result is a registered violation flag and a 3-bit reason code. When several faults coincide the smallest code wins. The checker only observes and does not stall anything.

Top module: `ptr_hazard_chk`

## Requirements
- R1: When the previous issued instruction wrote pointer register k (write kind 1) and the current one forms an address with pointer index k, in any mode, reason 1 is reported. An instruction issued two or more slots after the write is not flagged.
- R2: A write to offset register k (write kind 2) followed at once by an address use of index k is flagged with reason 2 only in the modes that read the offset, codes 6 and 7. Modes 0 to 5 give no offset hazard.
- R3: A write to modifier register k (write kind 3) followed at once by an address use of index k is flagged with reason 3 in modes 2 to 7. Mode 0 (no update) and mode 1 (pointer-relative to PC) give no hazard.
- R4: No distance hazard is reported when the index written differs from the index used.
- R5: When the previous issued instruction is a stack-pointer update, the current one gets reason 4 if it is a bit-test jump on stack-high or stack-low (class 5). The stack-pointer updates are a bit change, clear or set (class 1), a control move (class 2), a load-effective-address (class 3) or a load-relative-address (class 4). A bit-test jump that is not immediately preceded by one of these is not flagged.
- R6: A control move from stack-high to stack-high (class 6) always reports reason 5, whatever came before it.
- R7: While the fast-interrupt flag is high, classes 4, 7 (hardware loop start), 8 (trap or conditional trap), 9 (stop), 10 (wait) and 11 (PC-relative branch, call or bit-branch) report reason 6. Other classes, and these classes with the flag low, are not flagged for this rule.
- R8: A slot with the valid bit low raises no violation and does not advance the write record.
- R9: When several rules fire for one instruction, the lowest nonzero reason code is reported.
- R10: Reset clears the outputs and the write record, so the first instruction after reset raises no distance or pairing fault.
- R11: The flag and reason appear on the clock edge that samples the descriptor and hold until the next edge. The flag is high exactly when the reason is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vld_i | input | 1 | Slot holds an issued instruction |
| wr_kind_i | input | 3 | Register kind written: 0 none, 1 pointer, 2 offset, 3 modifier, 4 stack pointer |
| wr_idx_i | input | 3 | Index of the register written |
| addr_use_i | input | 1 | Instruction forms an address |
| use_idx_i | input | 3 | Pointer index used for the address |
| mode_i | input | 3 | Addressing mode code (0 no update, 1 PC-relative, 2 long displacement, 3 post+1, 4 post-1, 5 pre-1, 6 post+offset, 7 indexed by offset) |
| op_cls_i | input | 4 | Operation class code |
| fast_irq_i | input | 1 | Fast interrupt routine in progress |
| viol_o | output | 1 | Violation flag |
| reason_o | output | 3 | Reason code: 0 none, 1 pointer, 2 offset, 3 modifier, 4 stack pairing, 5 stack-high self move, 6 fast interrupt |

## Verification
A wrong write record shows as a missing or extra reason 1, 2 or 3 on the very next issued instruction that uses the affected index. If an idle slot wrongly shifts the record, a hazard vanishes one slot early. A wrong mode decode shows as a flag that appears or disappears for one particular mode code. A faulty encoder or a stack-update bit that is never set shows at the output one clock after the offending descriptor, as the wrong code when rules coincide or as a missing reason 4.

// File: rtl/ptr_hazard_pkg.sv
package ptr_hazard_pkg;

  typedef enum logic [2:0] {
    WK_NONE = 3'd0,
    WK_ADDR = 3'd1,
    WK_OFS  = 3'd2,
    WK_MOD  = 3'd3,
    WK_SP   = 3'd4
  } wr_kind_e;

  typedef enum logic [2:0] {
    AM_NOUPD    = 3'd0,
    AM_PCREL    = 3'd1,
    AM_LDISP    = 3'd2,
    AM_POSTINC1 = 3'd3,
    AM_POSTDEC1 = 3'd4,
    AM_PREDEC1  = 3'd5,
    AM_POSTINCN = 3'd6,
    AM_INDEXN   = 3'd7
  } amode_e;

  typedef enum logic [3:0] {
    OC_PLAIN    = 4'd0,
    OC_SP_BITOP = 4'd1,
    OC_SP_CTLMV = 4'd2,
    OC_SP_LEA   = 4'd3,
    OC_SP_LRA   = 4'd4,
    OC_SSX_BJMP = 4'd5,
    OC_SSH_SELF = 4'd6,
    OC_LOOP     = 4'd7,
    OC_TRAP     = 4'd8,
    OC_STOP     = 4'd9,
    OC_WAIT     = 4'd10,
    OC_PCREL    = 4'd11
  } op_cls_e;

  typedef enum logic [2:0] {
    RS_NONE  = 3'd0,
    RS_PTR   = 3'd1,
    RS_OFS   = 3'd2,
    RS_MOD   = 3'd3,
    RS_PAIR  = 3'd4,
    RS_SSHMV = 3'd5,
    RS_FAST  = 3'd6
  } reason_e;

  function automatic logic mode_reads_ofs(input logic [2:0] m);
    return (m == AM_POSTINCN) || (m == AM_INDEXN);
  endfunction

  function automatic logic mode_reads_mod(input logic [2:0] m);
    return !((m == AM_NOUPD) || (m == AM_PCREL));
  endfunction

  function automatic logic cls_updates_sp(input logic [3:0] c);
    return (c == OC_SP_BITOP) || (c == OC_SP_CTLMV) ||
           (c == OC_SP_LEA)   || (c == OC_SP_LRA);
  endfunction

  function automatic logic cls_fast_banned(input logic [3:0] c);
    return (c == OC_SP_LRA) || (c == OC_LOOP) || (c == OC_TRAP) ||
           (c == OC_STOP)   || (c == OC_WAIT) || (c == OC_PCREL);
  endfunction

endpackage

// File: rtl/ptr_hazard_hist.sv
module ptr_hazard_hist
  import ptr_hazard_pkg::*;
#(
  parameter int IDX_W   = 3,
  parameter int NUM_REG = 1 << IDX_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               vld_i,
  input  logic [2:0]         wr_kind_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [3:0]         op_cls_i,
  output logic [NUM_REG-1:0] a_last_o,
  output logic [NUM_REG-1:0] n_last_o,
  output logic [NUM_REG-1:0] m_last_o,
  output logic               sp_last_o
);

  logic [NUM_REG-1:0] a_nxt, n_nxt, m_nxt;

  for (genvar g = 0; g < NUM_REG; g++) begin : g_reg
    logic sel;
    assign sel      = (wr_idx_i == IDX_W'(g));
    assign a_nxt[g] = sel && (wr_kind_i == WK_ADDR);
    assign n_nxt[g] = sel && (wr_kind_i == WK_OFS);
    assign m_nxt[g] = sel && (wr_kind_i == WK_MOD);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_last_o  <= '0;
      n_last_o  <= '0;
      m_last_o  <= '0;
      sp_last_o <= 1'b0;
    end else if (vld_i) begin
      a_last_o  <= a_nxt;
      n_last_o  <= n_nxt;
      m_last_o  <= m_nxt;
      sp_last_o <= cls_updates_sp(op_cls_i);
    end
  end

  // idle slots must not advance the record
  p_hist_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> ($stable(a_last_o) && $stable(n_last_o) &&
                $stable(m_last_o) && $stable(sp_last_o)));

  // one register written per instruction
  p_hist_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({a_last_o, n_last_o, m_last_o}));

endmodule

// File: rtl/ptr_hazard_dist.sv
module ptr_hazard_dist
  import ptr_hazard_pkg::*;
#(
  parameter int IDX_W   = 3,
  parameter int NUM_REG = 1 << IDX_W
) (
  input  logic               vld_i,
  input  logic               addr_use_i,
  input  logic [IDX_W-1:0]   use_idx_i,
  input  logic [2:0]         mode_i,
  input  logic [NUM_REG-1:0] a_last_i,
  input  logic [NUM_REG-1:0] n_last_i,
  input  logic [NUM_REG-1:0] m_last_i,
  output logic               ptr_hit_o,
  output logic               ofs_hit_o,
  output logic               mod_hit_o
);

  logic uses;
  assign uses = vld_i && addr_use_i;

  always_comb begin
    ptr_hit_o = uses && a_last_i[use_idx_i];
    ofs_hit_o = uses && n_last_i[use_idx_i] && mode_reads_ofs(mode_i);
    mod_hit_o = uses && m_last_i[use_idx_i] && mode_reads_mod(mode_i);
  end

endmodule

// File: rtl/ptr_hazard_seq.sv
module ptr_hazard_seq
  import ptr_hazard_pkg::*;
(
  input  logic       vld_i,
  input  logic [3:0] op_cls_i,
  input  logic       fast_irq_i,
  input  logic       sp_last_i,
  output logic       pair_hit_o,
  output logic       sshmv_hit_o,
  output logic       fast_hit_o
);

  always_comb begin
    pair_hit_o  = vld_i && sp_last_i && (op_cls_i == OC_SSX_BJMP);
    sshmv_hit_o = vld_i && (op_cls_i == OC_SSH_SELF);
    fast_hit_o  = vld_i && fast_irq_i && cls_fast_banned(op_cls_i);
  end

endmodule

// File: rtl/ptr_hazard_chk.sv
module ptr_hazard_chk
  import ptr_hazard_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [2:0]       wr_kind_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             addr_use_i,
  input  logic [IDX_W-1:0] use_idx_i,
  input  logic [2:0]       mode_i,
  input  logic [3:0]       op_cls_i,
  input  logic             fast_irq_i,
  output logic             viol_o,
  output logic [2:0]       reason_o
);

  localparam int NUM_REG = 1 << IDX_W;

  logic [NUM_REG-1:0] a_last, n_last, m_last;
  logic               sp_last;
  logic               ptr_hit, ofs_hit, mod_hit;
  logic               pair_hit, sshmv_hit, fast_hit;
  logic [2:0]         reason_d;
  logic               viol_d;

  ptr_hazard_hist #(.IDX_W(IDX_W), .NUM_REG(NUM_REG)) u_hist (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vld_i     (vld_i),
    .wr_kind_i (wr_kind_i),
    .wr_idx_i  (wr_idx_i),
    .op_cls_i  (op_cls_i),
    .a_last_o  (a_last),
    .n_last_o  (n_last),
    .m_last_o  (m_last),
    .sp_last_o (sp_last)
  );

  ptr_hazard_dist #(.IDX_W(IDX_W), .NUM_REG(NUM_REG)) u_dist (
    .vld_i      (vld_i),
    .addr_use_i (addr_use_i),
    .use_idx_i  (use_idx_i),
    .mode_i     (mode_i),
    .a_last_i   (a_last),
    .n_last_i   (n_last),
    .m_last_i   (m_last),
    .ptr_hit_o  (ptr_hit),
    .ofs_hit_o  (ofs_hit),
    .mod_hit_o  (mod_hit)
  );

  ptr_hazard_seq u_seq (
    .vld_i       (vld_i),
    .op_cls_i    (op_cls_i),
    .fast_irq_i  (fast_irq_i),
    .sp_last_i   (sp_last),
    .pair_hit_o  (pair_hit),
    .sshmv_hit_o (sshmv_hit),
    .fast_hit_o  (fast_hit)
  );

  // lowest code wins
  always_comb begin
    if      (ptr_hit)   reason_d = RS_PTR;
    else if (ofs_hit)   reason_d = RS_OFS;
    else if (mod_hit)   reason_d = RS_MOD;
    else if (pair_hit)  reason_d = RS_PAIR;
    else if (sshmv_hit) reason_d = RS_SSHMV;
    else if (fast_hit)  reason_d = RS_FAST;
    else                reason_d = RS_NONE;
  end

  assign viol_d = ptr_hit | ofs_hit | mod_hit | pair_hit | sshmv_hit | fast_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      viol_o   <= 1'b0;
      reason_o <= RS_NONE;
    end else begin
      viol_o   <= viol_d;
      reason_o <= reason_d;
    end
  end

  p_flag_code_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o == (reason_o != RS_NONE));

  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> !viol_o);

  p_ssh_self_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && op_cls_i == OC_SSH_SELF) |=> (viol_o && reason_o <= RS_SSHMV));

  p_fast_ban_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && fast_irq_i && cls_fast_banned(op_cls_i)) |=> viol_o);

  p_pair_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && cls_updates_sp(op_cls_i)) ##1 (vld_i && op_cls_i == OC_SSX_BJMP)
      |=> (viol_o && reason_o <= RS_PAIR));

endmodule

// File: tb/ptr_hazard_chk_tb_top.sv
`timescale 1ns/1ps
module ptr_hazard_chk_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vld = 1'b0;
  logic [2:0] wk = '0, wi = '0, ui = '0, md = '0;
  logic       au = 1'b0, fst = 1'b0;
  logic [3:0] cls = '0;
  logic       viol;
  logic [2:0] reason;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  ptr_hazard_chk dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .vld_i      (vld),
    .wr_kind_i  (wk),
    .wr_idx_i   (wi),
    .addr_use_i (au),
    .use_idx_i  (ui),
    .mode_i     (md),
    .op_cls_i   (cls),
    .fast_irq_i (fst),
    .viol_o     (viol),
    .reason_o   (reason)
  );

  typedef struct packed {
    logic       v;
    logic [2:0] wk;
    logic [2:0] wi;
    logic       au;
    logic [2:0] ui;
    logic [2:0] md;
    logic [3:0] cls;
    logic       fst;
    logic [2:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 52;
  // fields: v, wr kind, wr idx, use, use idx, mode, class, fast, expected reason, req
  localparam vec_t VEC [NV] = '{
    '{1'b1,3'd1,3'd3,1'b0,3'd0,3'd0,4'd0,1'b0,3'd0,4'd1},  // R1 write ptr3
    '{1'b1,3'd0,3'd0,1'b1,3'd3,3'd0,4'd0,1'b0,3'd1,4'd1},  // R1 use ptr3 at once
    '{1'b1,3'd1,3'd5,1'b0,3'd0,3'd0,4'd0,1'b0,3'd0,4'd1},
    '{1'b1,3'd0,3'd0,1'b0,3'd0,3'd0,4'd0,1'b0,3'd0,4'd1},
    '{1'b1,3'd0,3'd0,1'b1,3'd5,3'd6,4'd0,1'b0,3'd0,4'd1},  // R1 second slot ok
    '{1'b1,3'd2,3'd2,1'b0,3'd0,3'd0,4'd0,1'b0,3'd0,4'd2},
    '{1'b1,3'd0,3'd0,1'b1,3'd2,3'd3,4'd0,1'b0,3'd0,4'd2},  // R2 post+1 ignores ofs
    '{1'b1,3'd2,3'd2,1'b0,3'd0,3'd0,4'd0,1'b0,3'd0,4'd2},
    '{1'b1,3'd0,3'd0,1'b1,3'd2,3'd6,4'd0,1'b0,3'd2,4'd2},  // R2 post+N
    '{1'b1,3'd2,3'd4,1'b0,3'd0,3'd0,4'd0,1'b0,3'd0,4'd2},
    '{1'b1,3'd0,3'd0,1'b1,3'd4,3'd7,4'd0,1'b0,3'd2,4'd2},  // R2 indexed
    '{1'b1,3'd2,3'd0,1'b0,3'd0,3'd0,4'd0,1'b0,3'd0,4'd2},
    '{1'b1,3'd0,3'd0,1'b1,3'd0,3'd5,4'd0,1'b0,3'd0,4'd2},  // R2 pre-1
    '{1'b1,3'd2,3'd0,1'b0,3'd0,3'd0,4'd0,1'b0,3'd0,4'd2},
    '{1'b1,3'd0,3'd0,1'b1,3'd0,3'd2,4'd0,1'b0,3'd0,4'd2},  // R2 long disp
    '{1'b1,3'd3,3'd1,1'b0,3'd0,3'd0,4'd0,1'b0,3'd0,4'd3},
    '{1'b1,3'd0,3'd0,1'b1,3'd1,3'd0,4'd0,1'b0,3'd0,4'd3},  // R3 no update
    '{1'b1,3'd3,3'd1,1'b0,3'd0,3'd0,4'd0,1'b0,3'd0,4'd3},
    '{1'b1,3'd0,3'd0,1'b1,3'd1,3'd2,4'd0,1'b0,3'd3,4'd3},  // R3 long disp
    '{1'b1,3'd3,3'd6,1'b0,3'd0,3'd0,4'd0,1'b0,3'd0,4'd3},
    '{1'b1,3'd0,3'd0,1'b1,3'd6,3'd1,4'd0,1'b0,3'd0,4'd3},  // R3 PC-relative
    '{1'b1,3'd3,3'd3,1'b0,3'd0,3'd0,4'd0,1'b0,3'd0,4'd3},
    '{1'b1,3'd0,3'd0,1'b1,3'd3,3'd5,4'd0,1'b0,3'd3,4'd3},  // R3 pre-1
    '{1'b1,3'd1,3'd2,1'b0,3'd0,3'd0,4'd0,1'b0,3'd0,4'd4},
    '{1'b1,3'd0,3'd0,1'b1,3'd3,3'd0,4'd0,1'b0,3'd0,4'd4},  // R4 index mismatch
    '{1'b1,3'd3,3'd7,1'b0,3'd0,3'd0,4'd0,1'b0,3'd0,4'd4},
    '{1'b1,3'd0,3'd0,1'b1,3'd0,3'd6,4'd0,1'b0,3'd0,4'd4},  // R4
    '{1'b0,3'd1,3'd1,1'b1,3'd1,3'd0,4'd6,1'b1,3'd0,4'd8},  // R8 idle quiet
    '{1'b1,3'd1,3'd4,1'b0,3'd0,3'd0,4'd0,1'b0,3'd0,4'd8},
    '{1'b0,3'd0,3'd0,1'b0,3'd0,3'd0,4'd0,1'b0,3'd0,4'd8},
    '{1'b0,3'd2,3'd4,1'b0,3'd0,3'd0,4'd0,1'b0,3'd0,4'd8},
    '{1'b1,3'd0,3'd0,1'b1,3'd4,3'd0,4'd0,1'b0,3'd1,4'd8},  // R8 hazard survives idle
    '{1'b1,3'd0,3'd0,1'b0,3'd0,3'd0,4'd1,1'b0,3'd0,4'd5},
    '{1'b1,3'd0,3'd0,1'b0,3'd0,3'd0,4'd5,1'b0,3'd4,4'd5},  // R5 bitop then bjmp
    '{1'b1,3'd0,3'd0,1'b0,3'd0,3'd0,4'd2,1'b0,3'd0,4'd5},
    '{1'b1,3'd0,3'd0,1'b0,3'd0,3'd0,4'd0,1'b0,3'd0,4'd5},
    '{1'b1,3'd0,3'd0,1'b0,3'd0,3'd0,4'd5,1'b0,3'd0,4'd5},  // R5 not adjacent
    '{1'b1,3'd0,3'd0,1'b0,3'd0,3'd0,4'd3,1'b0,3'd0,4'd5},
    '{1'b1,3'd0,3'd0,1'b0,3'd0,3'd0,4'd5,1'b0,3'd4,4'd5},  // R5 lea
    '{1'b1,3'd0,3'd0,1'b0,3'd0,3'd0,4'd4,1'b0,3'd0,4'd5},
    '{1'b1,3'd0,3'd0,1'b0,3'd0,3'd0,4'd5,1'b0,3'd4,4'd5},  // R5 lra
    '{1'b1,3'd0,3'd0,1'b0,3'd0,3'd0,4'd6,1'b0,3'd5,4'd6},  // R6
    '{1'b1,3'd0,3'd0,1'b0,3'd0,3'd0,4'd6,1'b0,3'd5,4'd6},  // R6 again
    '{1'b1,3'd0,3'd0,1'b0,3'd0,3'd0,4'd7,1'b1,3'd6,4'd7},  // R7 loop
    '{1'b1,3'd0,3'd0,1'b0,3'd0,3'd0,4'd0,1'b1,3'd0,4'd7},  // R7 plain in fast
    '{1'b1,3'd0,3'd0,1'b0,3'd0,3'd0,4'd8,1'b0,3'd0,4'd7},  // R7 trap outside
    '{1'b1,3'd0,3'd0,1'b0,3'd0,3'd0,4'd11,1'b1,3'd6,4'd7}, // R7 pc-rel
    '{1'b1,3'd0,3'd0,1'b0,3'd0,3'd0,4'd10,1'b1,3'd6,4'd7}, // R7 wait
    '{1'b1,3'd1,3'd0,1'b0,3'd0,3'd0,4'd1,1'b0,3'd0,4'd9},
    '{1'b1,3'd0,3'd0,1'b1,3'd0,3'd0,4'd5,1'b0,3'd1,4'd9},  // R9 ptr beats pair
    '{1'b1,3'd3,3'd2,1'b0,3'd0,3'd0,4'd0,1'b0,3'd0,4'd9},
    '{1'b1,3'd0,3'd0,1'b1,3'd2,3'd2,4'd7,1'b1,3'd3,4'd9}   // R9 mod beats fast
  };

  task automatic check(input logic [2:0] exp, input string tag);
    checks++;
    if (reason !== exp || viol !== (exp != 3'd0)) begin
      failures++;
      $display("FAIL %s reason=%0d viol=%0b expected reason=%0d viol=%0b",
               tag, reason, viol, exp, (exp != 3'd0));
    end
  endtask

  task automatic drive(input vec_t t);
    vld = t.v; wk = t.wk; wi = t.wi; au = t.au; ui = t.ui;
    md = t.md; cls = t.cls; fst = t.fst;
    @(posedge clk); #1;
  endtask

  task automatic idle();
    vld = 1'b0; wk = '0; wi = '0; au = 1'b0; ui = '0; md = '0; cls = '0; fst = 1'b0;
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL R11 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1;
    check(3'd0, "R10 reset state");
    rst_n = 1'b1;

    // R10: first use after reset is clean
    drive('{1'b1,3'd0,3'd0,1'b1,3'd0,3'd7,4'd5,1'b0,3'd0,4'd10});
    check(3'd0, "R10 first after reset");

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      check(VEC[i].exp, $sformatf("R%0d vec%0d", VEC[i].req, i));
    end

    // R11: output holds while next slot is idle
    drive('{1'b1,3'd0,3'd0,1'b0,3'd0,3'd0,4'd6,1'b0,3'd5,4'd11});
    check(3'd5, "R11 flag one clock later");
    idle();
    #1;
    check(3'd5, "R11 holds until edge");
    @(posedge clk); #1;
    check(3'd0, "R11 clears after idle");

    // R10: reset mid-run wipes the write record
    drive('{1'b1,3'd1,3'd1,1'b0,3'd0,3'd0,4'd2,1'b0,3'd0,4'd10});
    idle();
    rst_n = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    check(3'd0, "R10 outputs after reset");
    drive('{1'b1,3'd0,3'd0,1'b1,3'd1,3'd0,4'd5,1'b0,3'd0,4'd10});
    check(3'd0, "R10 history cleared");
    idle();
    @(posedge clk); #1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule